// File: doc/BRIEF.md
# Four-Channel Bus-Master Transfer Engine

This block moves data between memory and I/O devices on behalf of a processor. Each of four channels holds a 16-bit current address, a 16-bit current word count and a mode word, alongside a base copy of the address and count. The processor loads these through a small synchronous register port. A device asks for service by raising its request line, or software sets a request bit. If the channel is unmasked, the engine raises its bus request and waits for the grant. While the grant is held it drives the memory address, a read/write strobe pair and a one-hot acknowledge. After each transfer it steps the address and the count.

A transfer sequence ends on terminal count or on an external active-low end-of-process input. At terminal count the engine also pulls its own end-of-process output low. A channel either reloads itself from its base registers, so it keeps running, or masks itself. Single, block and demand modes decide when the bus is handed back. A command bit chooses between fixed and rotating priority among channels that request at the same time.

Register map (`cfg_addr`, 4 bits): 0–3 address of channel 0–3; 4–7 word count of channel 0–3; 8–11 mode of channel 0–3; 12 command; 13 mask; 14 software request; 15 status. Writing an address or count register loads both the base and the current copy. Reads return the current copy.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset the bus request is low, all acknowledges are low, all four strobes and the end-of-process output are high, the mask register reads 4'hF and the status register reads 0.
- R2: A pending channel raises `hold`. Nothing is transferred until `holda` is seen. During a transfer exactly one `dack` bit is high and `mem_addr` shows that channel's current address.
- R3: Mode bit 0 selects direction. With 1 (toward memory), `io_rd_n` and `mem_wr_n` are low during the transfer. With 0 (toward I/O), `mem_rd_n` and `io_wr_n` are low. All strobes are high outside transfers.
- R4: Mode bit 1 selects the address step: 0 adds one per transfer, 1 subtracts one.
- R5: A transfer made while the count is 0000h is the terminal one. The count then wraps to FFFFh and `eop_n_o` is low during that transfer.
- R6: Mode bit 2 (auto-reload) set: terminal count or external end reloads the current address and count from the base values, and the mask bit stays clear. Bit 2 clear: the channel's mask bit is set instead.
- R7: Mode bits 4:3 = 00 (single) perform one transfer per bus grant, then drop `hold`.
- R8: Mode bits 4:3 = 01 (block) keep transferring regardless of the request line until terminal count, or until `eop_n_i` is sampled low during a transfer. `hold` is dropped in the cycle after the final transfer.
- R9: Mode bits 4:3 = 10 (demand) also stop and drop `hold` when the channel's request is no longer active at the end of a transfer.
- R10: Status bits 3:0 are per-channel end flags, set at terminal count or on external end. Bits 7:4 show unmasked pending requests. Reading the status register clears bits 3:0.
- R11: Command bit 0 = 0 gives channel 0 the highest fixed priority. Command bit 0 = 1 rotates priority so that the channel just served becomes the lowest.
- R12: Software request bits (register 14, bit n for channel n) start service and are cleared when the channel ends. A set mask bit stops a channel from being served even while its request is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data, valid the cycle after `cfg_re` |
| dreq | input | 4 | Device request per channel |
| hold | output | 1 | Bus request to the processor |
| holda | input | 1 | Bus grant from the processor |
| dack | output | 4 | One-hot transfer acknowledge |
| mem_addr | output | 16 | Memory address during a transfer |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| eop_n_i | input | 1 | External end-of-process, active low |
| eop_n_o | output | 1 | Terminal-count indication, active low |

## Verification
The bound checker watches, on every cycle:
- that at most one acknowledge is high, and only under an asserted and granted bus request;
- that the strobes always form one of the two legal direction pairs, or are all idle;
- that the terminal-count output is low only inside a transfer, and that such a transfer is followed at once by release of the bus.

Only the scenarios can show the rest:
- the address sequence and the wrap of the count;
- reload versus self-masking;
- how the three modes differ in when they give the bus back;
- the service order under fixed and rotating priority;
- the clear-on-read status flags;
- that a masked request is ignored.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    XM_SINGLE = 2'd0,
    XM_BLOCK  = 2'd1,
    XM_DEMAND = 2'd2
  } xfer_mode_e;

  // mode word: [4:3] transfer mode, [2] auto-reload, [1] decrement, [0] toward memory
  typedef struct packed {
    xfer_mode_e xmode;
    logic       autoinit;
    logic       dec;
    logic       to_mem;
  } chan_mode_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_XFER = 2'd2,
    S_DONE = 2'd3
  } seq_state_e;

  localparam logic [1:0] GRP_ADDR   = 2'd0;
  localparam logic [1:0] GRP_COUNT  = 2'd1;
  localparam logic [1:0] GRP_MODE   = 2'd2;
  localparam logic [1:0] GRP_COMMON = 2'd3;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic          ld_mode,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  input  logic          finish,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output chan_mode_t    mode,
  output logic          tc
);
  logic [AW-1:0] base_addr;
  logic [CW-1:0] base_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
    end else begin
      if (ld_addr) begin
        base_addr <= wdata[AW-1:0];
        cur_addr  <= wdata[AW-1:0];
      end
      if (ld_cnt) begin
        base_cnt <= wdata[CW-1:0];
        cur_cnt  <= wdata[CW-1:0];
      end
      if (ld_mode) mode <= chan_mode_t'(wdata[4:0]);
      if (step) begin
        if (finish && mode.autoinit) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_cnt  <= cur_cnt - 1'b1;
          cur_addr <= mode.dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
        end
      end
    end
  end

  assign tc = (cur_cnt == '0);
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  input  logic           rotate,
  input  logic [CHW-1:0] ptr,
  output logic           any,
  output logic [CHW-1:0] gnt
);
  logic [CHW-1:0] start;
  logic           found;

  always_comb begin
    any   = |req;
    gnt   = '0;
    found = 1'b0;
    start = rotate ? ptr : '0;
    for (int k = 0; k < NCH; k++) begin
      logic [CHW-1:0] c;
      c = CHW'(start + CHW'(k));
      if (!found && req[c]) begin
        gnt   = c;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           any_req,
  input  logic [CHW-1:0] gnt,
  input  logic           holda,
  input  logic           stop,
  output logic [CHW-1:0] act,
  output logic [CHW-1:0] ptr,
  output logic           hold,
  output logic           xfer
);
  seq_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      act <= '0;
      ptr <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (any_req) begin
          act <= gnt;
          st  <= S_REQ;
        end
        S_REQ:  if (holda) st <= S_XFER;
        S_XFER: if (stop) begin
          st  <= S_DONE;
          ptr <= act + 1'b1;
        end
        S_DONE: if (!holda) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign hold = (st == S_REQ) || (st == S_XFER);
  assign xfer = (st == S_XFER);
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int DW  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic                     cfg_re,
  input  logic [$clog2(NCH)+1:0]   cfg_addr,
  input  logic [DW-1:0]            cfg_wdata,
  output logic [DW-1:0]            cfg_rdata,
  input  logic [NCH-1:0]           dreq,
  output logic                     hold,
  input  logic                     holda,
  output logic [NCH-1:0]           dack,
  output logic [AW-1:0]            mem_addr,
  output logic                     mem_rd_n,
  output logic                     mem_wr_n,
  output logic                     io_rd_n,
  output logic                     io_wr_n,
  input  logic                     eop_n_i,
  output logic                     eop_n_o
);
  localparam int CHW = $clog2(NCH);
  localparam int RAW = CHW + 2;
  localparam logic [CHW-1:0] IDX_CMD  = CHW'(0);
  localparam logic [CHW-1:0] IDX_MASK = CHW'(1);
  localparam logic [CHW-1:0] IDX_REQ  = CHW'(2);
  localparam logic [CHW-1:0] IDX_STAT = CHW'(3);

  logic [NCH-1:0] mask_q, swreq_q, flag_q;
  logic           rot_q;
  logic [DW-1:0]  rdata_q, rd_mux;

  logic [AW-1:0]  ch_addr [NCH];
  logic [CW-1:0]  ch_cnt  [NCH];
  chan_mode_t     ch_mode [NCH];
  logic [NCH-1:0] ch_tc;

  logic [CHW-1:0] act, ptr, gnt;
  logic           any_req, xfer, stop, finish, eop_ext;
  logic [NCH-1:0] raw_req, pend;
  logic [1:0]     grp;
  logic [CHW-1:0] idx;
  chan_mode_t     amode;

  assign grp     = cfg_addr[RAW-1:CHW];
  assign idx     = cfg_addr[CHW-1:0];
  assign raw_req = dreq | swreq_q;
  assign pend    = raw_req & ~mask_q;
  assign amode   = ch_mode[act];
  assign eop_ext = ~eop_n_i;
  assign finish  = xfer && (ch_tc[act] || eop_ext);
  assign stop    = finish || (amode.xmode == XM_SINGLE) ||
                   ((amode.xmode == XM_DEMAND) && !raw_req[act]);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .ld_addr  (cfg_we && grp == GRP_ADDR  && idx == CHW'(g)),
      .ld_cnt   (cfg_we && grp == GRP_COUNT && idx == CHW'(g)),
      .ld_mode  (cfg_we && grp == GRP_MODE  && idx == CHW'(g)),
      .wdata    (cfg_wdata),
      .step     (xfer && act == CHW'(g)),
      .finish   (finish && act == CHW'(g)),
      .cur_addr (ch_addr[g]),
      .cur_cnt  (ch_cnt[g]),
      .mode     (ch_mode[g]),
      .tc       (ch_tc[g])
    );
  end

  dma_arb #(.NCH(NCH)) u_arb (
    .req    (pend),
    .rotate (rot_q),
    .ptr    (ptr),
    .any    (any_req),
    .gnt    (gnt)
  );

  dma_seq #(.NCH(NCH)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .any_req (any_req),
    .gnt     (gnt),
    .holda   (holda),
    .stop    (stop),
    .act     (act),
    .ptr     (ptr),
    .hold    (hold),
    .xfer    (xfer)
  );

  always_comb begin
    rd_mux = '0;
    unique case (grp)
      GRP_ADDR:  rd_mux = DW'(ch_addr[idx]);
      GRP_COUNT: rd_mux = DW'(ch_cnt[idx]);
      GRP_MODE:  rd_mux = DW'(ch_mode[idx]);
      default: begin
        unique case (idx)
          IDX_CMD:  rd_mux = DW'(rot_q);
          IDX_MASK: rd_mux = DW'(mask_q);
          IDX_REQ:  rd_mux = DW'(swreq_q);
          default:  rd_mux = DW'({pend, flag_q});
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      swreq_q <= '0;
      flag_q  <= '0;
      rot_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (cfg_we && grp == GRP_COMMON) begin
        unique case (idx)
          IDX_CMD:  rot_q   <= cfg_wdata[0];
          IDX_MASK: mask_q  <= cfg_wdata[NCH-1:0];
          IDX_REQ:  swreq_q <= cfg_wdata[NCH-1:0];
          default: ;
        endcase
      end
      if (cfg_re && grp == GRP_COMMON && idx == IDX_STAT) flag_q <= '0;
      if (finish) begin
        flag_q[act]  <= 1'b1;
        swreq_q[act] <= 1'b0;
        if (!amode.autoinit) mask_q[act] <= 1'b1;
      end
      if (cfg_re) rdata_q <= rd_mux;
    end
  end

  always_comb begin
    for (int k = 0; k < NCH; k++) dack[k] = xfer && (act == CHW'(k));
  end

  assign cfg_rdata = rdata_q;
  assign mem_addr  = xfer ? ch_addr[act] : '0;
  assign mem_rd_n  = !(xfer && !amode.to_mem);
  assign io_wr_n   = !(xfer && !amode.to_mem);
  assign io_rd_n   = !(xfer && amode.to_mem);
  assign mem_wr_n  = !(xfer && amode.to_mem);
  assign eop_n_o   = !(xfer && ch_tc[act]);
endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           hold,
  input logic           holda,
  input logic [NCH-1:0] dack,
  input logic           mem_rd_n,
  input logic           mem_wr_n,
  input logic           io_rd_n,
  input logic           io_wr_n,
  input logic           eop_n_o
);
  AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dack)); // R2
  AST_DACK_GRANTED: assert property (@(posedge clk) disable iff (rst)
    (|dack) |-> (hold && holda)); // R2
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (rst)
    (dack == '0) |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n)); // R3
  AST_DIR_PAIR: assert property (@(posedge clk) disable iff (rst)
    (|dack) |-> ((!mem_rd_n && !io_wr_n && io_rd_n && mem_wr_n) ||
                 (!io_rd_n && !mem_wr_n && mem_rd_n && io_wr_n))); // R3
  AST_TC_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    !eop_n_o |-> (|dack)); // R5
  AST_TC_RELEASES: assert property (@(posedge clk) disable iff (rst)
    ((|dack) && !eop_n_o) |=> (!hold && dack == '0)); // R8
endmodule

bind dma4_ctrl dma4_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hold     (hold),
  .holda    (holda),
  .dack     (dack),
  .mem_rd_n (mem_rd_n),
  .mem_wr_n (mem_wr_n),
  .io_rd_n  (io_rd_n),
  .io_wr_n  (io_wr_n),
  .eop_n_o  (eop_n_o)
);

// File: tb/tb_dma4_ctrl.sv
`timescale 1ns/1ps
module tb_dma4_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [3:0]  dreq = '0;
  logic        hold;
  logic        holda = 1'b0;
  logic        holda_en = 1'b1;
  logic [3:0]  dack;
  logic [15:0] mem_addr;
  logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
  logic        eop_n_i = 1'b1;
  logic        eop_n_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          ch;
    logic [15:0] addr;
    bit          to_mem;
    bit          last;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  dma4_ctrl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq), .hold(hold),
    .holda(holda), .dack(dack), .mem_addr(mem_addr), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .eop_n_i(eop_n_i), .eop_n_o(eop_n_o)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 1'b0;
    check(cfg_rdata == exp, tag, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic push(int ch, logic [15:0] a, bit to_mem, bit last, string tag);
    exp_t e;
    e.ch = ch; e.addr = a; e.to_mem = to_mem; e.last = last; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // raise dreq[ch], wait for n acknowledges on ch, then act at that edge
  task automatic run_dreq(int ch, int n, bit drop, bit pulse_eop, output int rises);
    int cnt = 0;
    logic prev_h = hold;
    rises = 0;
    dreq[ch] = 1'b1;
    while (cnt < n) begin
      @(negedge clk);
      if (hold && !prev_h) rises++;
      prev_h = hold;
      if (dack[ch]) cnt++;
    end
    if (drop) dreq[ch] = 1'b0;
    if (pulse_eop) begin
      eop_n_i = 1'b0;
      @(negedge clk);
      eop_n_i = 1'b1;
    end
  endtask

  task automatic run_sw(int ch, int n, bit pulse_eop);
    int cnt = 0;
    while (cnt < n) begin
      @(negedge clk);
      if (dack[ch]) cnt++;
    end
    if (pulse_eop) begin
      eop_n_i = 1'b0;
      @(negedge clk);
      eop_n_i = 1'b1;
    end
  endtask

  // bus-grant model
  initial forever begin
    @(negedge clk);
    holda <= hold & holda_en;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (!rst && dack != '0) begin
      if (sb.size() == 0) begin
        check(1'b0, "R12 unexpected transfer", {12'h0, dack, mem_addr}, 32'h0);
      end else begin
        exp_t e;
        logic [24:0] av, ev;
        e  = sb.pop_front();
        av = {dack, mem_addr, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, eop_n_o};
        ev = {4'(1 << e.ch), e.addr, (e.to_mem ? 4'b1001 : 4'b0110), !e.last};
        check(av == ev, e.tag, 32'(av), 32'(ev));
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!hold && dack == 0, "R1 hold/dack", {hold, dack}, 0);
    check({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, eop_n_o} == 5'h1F, "R1 strobes",
          {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, eop_n_o}, 5'h1F);
    rd_chk(4'd13, 16'h000F, "R1 mask reset");
    rd_chk(4'd15, 16'h0000, "R1 status reset");

    // block mode, ch1, increment, toward memory, software request
    wr(4'd1, 16'h1000); wr(4'd5, 16'd2); wr(4'd9, 16'h0009);
    push(1, 16'h1000, 1, 0, "R8 block xfer0");
    push(1, 16'h1001, 1, 0, "R4 block xfer1");
    push(1, 16'h1002, 1, 1, "R5 block tc");
    wr(4'd13, 16'h000D);
    wr(4'd14, 16'h0002);
    drain();
    rd_chk(4'd15, 16'h0002, "R10 tc flag ch1");
    rd_chk(4'd15, 16'h0000, "R10 clear on read");
    rd_chk(4'd13, 16'h000F, "R6 self-mask");
    rd_chk(4'd5, 16'hFFFF, "R5 count wrap");
    rd_chk(4'd1, 16'h1003, "R4 address after");
    rd_chk(4'd14, 16'h0000, "R12 sw request cleared");

    // single mode, ch2, decrement, toward I/O, auto-reload
    wr(4'd2, 16'h2000); wr(4'd6, 16'd1); wr(4'd10, 16'h0006);
    push(2, 16'h2000, 0, 0, "R3 single to io");
    push(2, 16'h1FFF, 0, 1, "R4 decrement");
    push(2, 16'h2000, 0, 0, "R6 reload addr");
    push(2, 16'h1FFF, 0, 1, "R6 second tc");
    wr(4'd13, 16'h000B);
    run_dreq(2, 4, 1'b1, 1'b0, r);
    check(r == 4, "R7 one grant per transfer", 32'(r), 4);
    drain();
    rd_chk(4'd13, 16'h000B, "R6 stays unmasked");
    rd_chk(4'd15, 16'h0004, "R10 flag ch2");
    rd_chk(4'd2, 16'h2000, "R6 address reloaded");
    rd_chk(4'd6, 16'h0001, "R6 count reloaded");
    wr(4'd13, 16'h000F);

    // demand mode, ch3, request dropped after three transfers
    wr(4'd3, 16'h3000); wr(4'd7, 16'd9); wr(4'd11, 16'h0011);
    push(3, 16'h3000, 1, 0, "R9 demand xfer0");
    push(3, 16'h3001, 1, 0, "R9 demand xfer1");
    push(3, 16'h3002, 1, 0, "R9 demand xfer2");
    wr(4'd13, 16'h0007);
    run_dreq(3, 3, 1'b1, 1'b0, r);
    check(r == 1, "R9 single burst", 32'(r), 1);
    drain();
    rd_chk(4'd7, 16'd6, "R9 count after stop");
    rd_chk(4'd15, 16'h0000, "R9 no end flag");
    wr(4'd13, 16'h000F);

    // block mode ch0 ended by external end-of-process
    wr(4'd0, 16'h0400); wr(4'd4, 16'd9); wr(4'd8, 16'h0009);
    push(0, 16'h0400, 1, 0, "R8 eop xfer0");
    push(0, 16'h0401, 1, 0, "R8 eop xfer1");
    wr(4'd13, 16'h000E);
    wr(4'd14, 16'h0001);
    run_sw(0, 2, 1'b1);
    drain();
    rd_chk(4'd15, 16'h0001, "R10 flag on external end");
    rd_chk(4'd13, 16'h000F, "R8 masked after external end");
    rd_chk(4'd14, 16'h0000, "R12 sw request cleared eop");
    rd_chk(4'd4, 16'd7, "R8 count after external end");

    // fixed priority ch0 over ch2, masked ch3 ignored
    wr(4'd0, 16'h0500); wr(4'd4, 16'd0); wr(4'd8, 16'h0001);
    wr(4'd2, 16'h2500); wr(4'd6, 16'd0); wr(4'd10, 16'h0001);
    dreq[3] = 1'b1;
    push(0, 16'h0500, 1, 1, "R11 fixed first ch0");
    push(2, 16'h2500, 1, 1, "R11 fixed then ch2");
    wr(4'd13, 16'h000A);
    wr(4'd14, 16'h0005);
    drain();
    rd_chk(4'd15, 16'h0005, "R12 masked ch3 not pending");
    dreq[3] = 1'b0;

    // rotating priority ch1/ch2
    wr(4'd12, 16'h0001);
    wr(4'd1, 16'h1100); wr(4'd5, 16'd1); wr(4'd9, 16'h0001);
    wr(4'd2, 16'h2200); wr(4'd6, 16'd1); wr(4'd10, 16'h0001);
    push(1, 16'h1100, 1, 0, "R11 rotate ch1");
    push(2, 16'h2200, 1, 0, "R11 rotate ch2");
    push(1, 16'h1101, 1, 1, "R11 rotate ch1 again");
    push(2, 16'h2201, 1, 1, "R11 rotate ch2 again");
    wr(4'd13, 16'h0009);
    wr(4'd14, 16'h0006);
    drain();
    rd_chk(4'd15, 16'h0006, "R10 flags ch1 ch2");
    rd_chk(4'd12, 16'h0001, "R11 command readback");

    // grant withheld: request waits, pending visible
    holda_en = 1'b0;
    wr(4'd3, 16'h3300); wr(4'd7, 16'd0); wr(4'd11, 16'h0009);
    wr(4'd13, 16'h0007);
    dreq[3] = 1'b1;
    repeat (6) @(negedge clk);
    check(hold && dack == 0, "R2 wait for grant", {hold, dack}, 5'h10);
    rd_chk(4'd15, 16'h0080, "R10 pending bit");
    push(3, 16'h3300, 1, 1, "R2 after grant");
    holda_en = 1'b1;
    drain();
    dreq[3] = 1'b0;
    rd_chk(4'd15, 16'h0008, "R10 flag ch3");
    check(sb.size() == 0, "R2 scoreboard empty", 32'(sb.size()), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule